// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out and takes back power-of-two blocks of a memory pool using the buddy method. The pool spans 2^MAX_ORD address units, and the smallest block it will give out spans 2^MIN_ORD units. A requester sends an allocation request with a size. The block answers with the base address and the order of a block that holds that size, or with a failure. A free request gives back a block by its base address and order. The block then merges the returned block with its buddy, and repeats this upward through the orders for as long as the buddies are free.

The block keeps two bitmaps for each order: one marks free blocks and one marks allocated blocks, and both are indexed by block number. An allocation searches upward from the order it needs and takes the lowest free block of the first order that has one. It then halves that block one order per cycle, and the upper half of each split stays free. The allocated bitmap lets a free request that does not name a block that is out right now be refused, with no change to the pool. Requests and responses use valid/ready handshakes, and `busy` is high from the moment a request is accepted until its response has been taken.

Top module: `buddy_alloc_top`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are low and `req_ready` is high. The pool is a single free block of order MAX_ORD, so the first request for 2^MAX_ORD units returns address 0 at order MAX_ORD.
- R2: An allocation of size S is served at the smallest order i, with MIN_ORD <= i <= MAX_ORD, for which S <= 2^i. Every size from 0 to 2^MIN_ORD maps to MIN_ORD, and `rsp_order` reports the order served.
- R3: If the target order has no free block, the orders above it are searched in increasing order. The lowest order that has a free block is used, and within that order the block with the lowest address is taken.
- R4: A larger block is halved into buddies, one split per clock, down to the target order. The lower half is kept and the upper half stays free. The number of cycles with `busy` high and `rsp_valid` low after acceptance is 1 plus the number of splits.
- R5: An allocation with size above 2^MAX_ORD returns `rsp_ok`=0 with address 0 and order 0, and the pool is left unchanged.
- R6: An allocation for which no order from the target up to MAX_ORD holds a free block returns `rsp_ok`=0 with address 0 and order 0, and the pool is left unchanged.
- R7: A freed block merges with its free buddy into the next order, one merge per clock, and this repeats upward. A free takes 2 plus the number of merges in cycles with `busy` high and `rsp_valid` low. Once every block has been returned, a 2^MAX_ORD allocation succeeds again.
- R8: The buddy of the block at order k with base A is at A XOR 2^k. If that buddy is not wholly free at order k, no merge takes place, and the freed block can be handed out again at its own address.
- R9: A free of a block that is not allocated at that order fails with `rsp_ok`=0 and changes nothing. This covers a block already freed, a misaligned address, and an order outside MIN_ORD..MAX_ORD. Every free response echoes the requested address and order.
- R10: `req_op` 0 means allocate and 1 means free, and `rsp_op` echoes it. `req_ready` is high only when the block is idle. A response holds its fields stable until `rsp_ready` is high, and `busy` stays high from acceptance until the response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 1 | 0 allocate, 1 free |
| req_size | input | MAX_ORD+2 | Allocation size in address units |
| req_addr | input | MAX_ORD | Base address of the block to free |
| req_order | input | clog2(MAX_ORD+1) | Order of the block to free |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_op | output | 1 | Operation this response answers |
| rsp_ok | output | 1 | 1 success, 0 failure or refused free |
| rsp_addr | output | MAX_ORD | Allocated base address, or the echoed free address |
| rsp_order | output | clog2(MAX_ORD+1) | Allocated order, or the echoed free order |
| busy | output | 1 | An operation is in progress |

## Verification
The assertions assume that the requester keeps `req_size` steady from the accepting edge onward and that `rsp_ready` is a clean level. The bench meets both by driving every input one time unit after a rising edge and by issuing a new request only once the previous response has been taken. The fit check on responses is only meaningful for allocations, so it is guarded by `rsp_op`. Free requests are aimed at allocated blocks whose addresses the bench tracks itself, and also, on purpose, at blocks that are not allocated. Only the refusal path of R9 reacts to that second kind.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FIND  = 3'd1,
    ST_SPLIT = 3'd2,
    ST_MERGE = 3'd3,
    ST_RESP  = 3'd4
  } buddy_state_e;

  localparam logic OP_ALLOC = 1'b0;
  localparam logic OP_FREE  = 1'b1;
endpackage

// File: rtl/buddy_size_order.sv
// Maps a request size onto the smallest order whose block holds it.
module buddy_size_order #(
  parameter int MIN_ORD = 4,
  parameter int MAX_ORD = 8,
  localparam int SW = MAX_ORD + 2,
  localparam int OW = $clog2(MAX_ORD + 1)
) (
  input  logic [SW-1:0] size,
  output logic [OW-1:0] order,
  output logic          oversize
);
  logic found;

  always_comb begin
    order    = OW'(MAX_ORD);
    found    = 1'b0;
    oversize = size > (SW'(1) << MAX_ORD);
    for (int i = MIN_ORD; i <= MAX_ORD; i++) begin
      if (!found && size <= (SW'(1) << i)) begin
        order = OW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/buddy_free_scan.sv
// Finds the lowest-addressed free block in the lowest order at or above min_ord.
module buddy_free_scan #(
  parameter int MIN_ORD = 4,
  parameter int MAX_ORD = 8,
  localparam int NLVL = MAX_ORD - MIN_ORD + 1,
  localparam int IW   = MAX_ORD - MIN_ORD,
  localparam int NBLK = 1 << IW,
  localparam int OW   = $clog2(MAX_ORD + 1)
) (
  input  logic [NLVL-1:0][NBLK-1:0] free_map,
  input  logic [OW-1:0]             min_ord,
  output logic                      hit,
  output logic [OW-1:0]             hit_ord,
  output logic [IW-1:0]             hit_idx
);
  logic          lvl_any [NLVL];
  logic [IW-1:0] lvl_idx [NLVL];

  genvar g;
  for (g = 0; g < NLVL; g++) begin : g_lvl
    always_comb begin
      lvl_any[g] = |free_map[g];
      lvl_idx[g] = '0;
      for (int b = NBLK - 1; b >= 0; b--) begin
        if (free_map[g][b]) lvl_idx[g] = IW'(b);
      end
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_ord = '0;
    hit_idx = '0;
    for (int j = 0; j < NLVL; j++) begin
      if (!hit && lvl_any[j] && (j + MIN_ORD) >= int'(min_ord)) begin
        hit     = 1'b1;
        hit_ord = OW'(j + MIN_ORD);
        hit_idx = lvl_idx[j];
      end
    end
  end
endmodule

// File: rtl/buddy_map.sv
// One bit per block per order, with one set port and one clear port.
module buddy_map #(
  parameter int NLVL     = 5,
  parameter int NBLK     = 16,
  parameter bit INIT_TOP = 1'b0,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_en,
  input  logic [LW-1:0]             set_lvl,
  input  logic [IW-1:0]             set_idx,
  input  logic                      clr_en,
  input  logic [LW-1:0]             clr_lvl,
  input  logic [IW-1:0]             clr_idx,
  output logic [NLVL-1:0][NBLK-1:0] map_q
);
  localparam logic [NLVL*NBLK-1:0] RST_FLAT =
    INIT_TOP ? ((NLVL*NBLK)'(1) << ((NLVL - 1) * NBLK)) : '0;

  logic [NLVL-1:0][NBLK-1:0] map_d;
  logic                      map_en;

  assign map_en = set_en | clr_en;

  always_comb begin
    map_d = map_q;
    if (clr_en) map_d[clr_lvl][clr_idx] = 1'b0;
    if (set_en) map_d[set_lvl][set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= RST_FLAT;
    else if (map_en) map_q <= map_d;
  end
endmodule

// File: rtl/buddy_alloc_top.sv
module buddy_alloc_top
  import buddy_pkg::*;
#(
  parameter int MIN_ORD = 4,
  parameter int MAX_ORD = 8,
  localparam int AW   = MAX_ORD,
  localparam int SW   = MAX_ORD + 2,
  localparam int OW   = $clog2(MAX_ORD + 1),
  localparam int NLVL = MAX_ORD - MIN_ORD + 1,
  localparam int IW   = MAX_ORD - MIN_ORD,
  localparam int NBLK = 1 << IW,
  localparam int LW   = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [SW-1:0] req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [OW-1:0] req_order,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_op,
  output logic          rsp_ok,
  output logic [AW-1:0] rsp_addr,
  output logic [OW-1:0] rsp_order,
  output logic          busy
);
  function automatic logic [LW-1:0] lvl_of(input logic [OW-1:0] o);
    return LW'(o - OW'(MIN_ORD));
  endfunction

  function automatic logic [IW-1:0] idx_of(input logic [AW-1:0] a, input logic [OW-1:0] o);
    return IW'(a >> o);
  endfunction

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  buddy_state_e  state_q, state_d;
  logic          op_q, op_d;
  logic [SW-1:0] size_q, size_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [OW-1:0] ord_q, ord_d;
  logic [AW-1:0] cur_addr_q, cur_addr_d;
  logic [OW-1:0] cur_ord_q, cur_ord_d;
  logic [OW-1:0] tgt_ord_q, tgt_ord_d;
  logic          ok_q, ok_d;
  logic [AW-1:0] raddr_q, raddr_d;
  logic [OW-1:0] rord_q, rord_d;
  logic          req_acc;
  logic          work_en;

  logic [NLVL-1:0][NBLK-1:0] free_map, used_map;
  logic          fset_en, fclr_en, uset_en, uclr_en;
  logic [LW-1:0] fset_lvl, fclr_lvl, uset_lvl, uclr_lvl;
  logic [IW-1:0] fset_idx, fclr_idx, uset_idx, uclr_idx;

  logic [OW-1:0] fit_ord;
  logic          fit_over;
  logic          scan_hit;
  logic [OW-1:0] scan_ord;
  logic [IW-1:0] scan_idx;

  buddy_size_order #(.MIN_ORD(MIN_ORD), .MAX_ORD(MAX_ORD)) u_fit (
    .size     (size_q),
    .order    (fit_ord),
    .oversize (fit_over)
  );

  buddy_free_scan #(.MIN_ORD(MIN_ORD), .MAX_ORD(MAX_ORD)) u_scan (
    .free_map (free_map),
    .min_ord  (fit_ord),
    .hit      (scan_hit),
    .hit_ord  (scan_ord),
    .hit_idx  (scan_idx)
  );

  buddy_map #(.NLVL(NLVL), .NBLK(NBLK), .INIT_TOP(1'b1)) u_free_map (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_en  (fset_en),
    .set_lvl (fset_lvl),
    .set_idx (fset_idx),
    .clr_en  (fclr_en),
    .clr_lvl (fclr_lvl),
    .clr_idx (fclr_idx),
    .map_q   (free_map)
  );

  buddy_map #(.NLVL(NLVL), .NBLK(NBLK), .INIT_TOP(1'b0)) u_used_map (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_en  (uset_en),
    .set_lvl (uset_lvl),
    .set_idx (uset_idx),
    .clr_en  (uclr_en),
    .clr_lvl (uclr_lvl),
    .clr_idx (uclr_idx),
    .map_q   (used_map)
  );

  assign req_acc = (state_q == ST_IDLE) && req_valid;

  // next-state logic
  logic          rng_ok, algn_ok, used_hit;
  logic [OW-1:0] nord;
  logic [AW-1:0] base, buddy;

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    size_d     = size_q;
    addr_d     = addr_q;
    ord_d      = ord_q;
    cur_addr_d = cur_addr_q;
    cur_ord_d  = cur_ord_q;
    tgt_ord_d  = tgt_ord_q;
    ok_d       = ok_q;
    raddr_d    = raddr_q;
    rord_d     = rord_q;
    fset_en = 1'b0; fset_lvl = '0; fset_idx = '0;
    fclr_en = 1'b0; fclr_lvl = '0; fclr_idx = '0;
    uset_en = 1'b0; uset_lvl = '0; uset_idx = '0;
    uclr_en = 1'b0; uclr_lvl = '0; uclr_idx = '0;
    rng_ok   = (ord_q >= OW'(MIN_ORD)) && (ord_q <= OW'(MAX_ORD));
    algn_ok  = (addr_q & ((AW'(1) << ord_q) - AW'(1))) == '0;
    used_hit = 1'b0;
    if (rng_ok) used_hit = used_map[lvl_of(ord_q)][idx_of(addr_q, ord_q)];
    nord  = cur_ord_q - OW'(1);
    base  = AW'(scan_idx) << scan_ord;
    buddy = cur_addr_q ^ (AW'(1) << cur_ord_q);

    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d    = req_op;
          size_d  = req_size;
          addr_d  = req_addr;
          ord_d   = req_order;
          state_d = ST_FIND;
        end
      end
      ST_FIND: begin
        if (op_q == OP_ALLOC) begin
          if (fit_over || !scan_hit) begin
            ok_d    = 1'b0;
            raddr_d = '0;
            rord_d  = '0;
            state_d = ST_RESP;
          end else begin
            fclr_en    = 1'b1;
            fclr_lvl   = lvl_of(scan_ord);
            fclr_idx   = scan_idx;
            cur_addr_d = base;
            cur_ord_d  = scan_ord;
            tgt_ord_d  = fit_ord;
            if (scan_ord == fit_ord) begin
              uset_en  = 1'b1;
              uset_lvl = lvl_of(fit_ord);
              uset_idx = scan_idx;
              ok_d     = 1'b1;
              raddr_d  = base;
              rord_d   = fit_ord;
              state_d  = ST_RESP;
            end else begin
              state_d = ST_SPLIT;
            end
          end
        end else begin
          raddr_d = addr_q;
          rord_d  = ord_q;
          if (rng_ok && algn_ok && used_hit) begin
            uclr_en    = 1'b1;
            uclr_lvl   = lvl_of(ord_q);
            uclr_idx   = idx_of(addr_q, ord_q);
            cur_addr_d = addr_q;
            cur_ord_d  = ord_q;
            ok_d       = 1'b1;
            state_d    = ST_MERGE;
          end else begin
            ok_d    = 1'b0;
            state_d = ST_RESP;
          end
        end
      end
      ST_SPLIT: begin
        fset_en   = 1'b1;
        fset_lvl  = lvl_of(nord);
        fset_idx  = idx_of(cur_addr_q | (AW'(1) << nord), nord);
        cur_ord_d = nord;
        if (nord == tgt_ord_q) begin
          uset_en  = 1'b1;
          uset_lvl = lvl_of(nord);
          uset_idx = idx_of(cur_addr_q, nord);
          raddr_d  = cur_addr_q;
          rord_d   = nord;
          ok_d     = 1'b1;
          state_d  = ST_RESP;
        end
      end
      ST_MERGE: begin
        if ((cur_ord_q < OW'(MAX_ORD)) &&
            free_map[lvl_of(cur_ord_q)][idx_of(buddy, cur_ord_q)]) begin
          fclr_en    = 1'b1;
          fclr_lvl   = lvl_of(cur_ord_q);
          fclr_idx   = idx_of(buddy, cur_ord_q);
          cur_addr_d = cur_addr_q & ~(AW'(1) << cur_ord_q);
          cur_ord_d  = cur_ord_q + OW'(1);
        end else begin
          fset_en  = 1'b1;
          fset_lvl = lvl_of(cur_ord_q);
          fset_idx = idx_of(cur_addr_q, cur_ord_q);
          state_d  = ST_RESP;
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign work_en = (state_q == ST_FIND) || (state_q == ST_SPLIT) || (state_q == ST_MERGE);

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q   <= OP_ALLOC;
      size_q <= '0;
      addr_q <= '0;
      ord_q  <= '0;
    end else if (req_acc) begin
      op_q   <= op_d;
      size_q <= size_d;
      addr_q <= addr_d;
      ord_q  <= ord_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cur_addr_q <= '0;
      cur_ord_q  <= '0;
      tgt_ord_q  <= '0;
      ok_q       <= 1'b0;
      raddr_q    <= '0;
      rord_q     <= '0;
    end else if (work_en) begin
      cur_addr_q <= cur_addr_d;
      cur_ord_q  <= cur_ord_d;
      tgt_ord_q  <= tgt_ord_d;
      ok_q       <= ok_d;
      raddr_q    <= raddr_d;
      rord_q     <= rord_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_op    = op_q;
  assign rsp_ok    = ok_q;
  assign rsp_addr  = raddr_q;
  assign rsp_order = rord_q;
endmodule

// File: rtl/buddy_alloc_checker.sv
module buddy_alloc_checker #(
  parameter int MIN_ORD = 4,
  parameter int MAX_ORD = 8,
  localparam int AW = MAX_ORD,
  localparam int SW = MAX_ORD + 2,
  localparam int OW = $clog2(MAX_ORD + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [SW-1:0] req_size,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_op,
  input logic          rsp_ok,
  input logic [AW-1:0] rsp_addr,
  input logic [OW-1:0] rsp_order,
  input logic          busy
);
  logic [SW-1:0] size_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      size_seen <= '0;
    else if (req_valid && req_ready) size_seen <= req_size;
  end

  // R10: accepted request makes the block busy and closes the request port
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  // R10: a stalled response keeps its content
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok) &&
                                $stable(rsp_addr) && $stable(rsp_order));

  // R4: a granted block is aligned to its order and the order is in range
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok |->
      ((rsp_addr & ((AW'(1) << rsp_order) - AW'(1))) == '0) &&
      (rsp_order >= OW'(MIN_ORD)) && (rsp_order <= OW'(MAX_ORD)));

  // R2: a granted order is the tightest one for the requested size
  a_r2_tight_fit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok && !rsp_op |->
      (size_seen <= (SW'(1) << rsp_order)) &&
      ((rsp_order == OW'(MIN_ORD)) || (size_seen > (SW'(1) << (rsp_order - OW'(1))))));

  // R5: oversized allocations never succeed
  a_r5_oversize_fails: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_op && (size_seen > (SW'(1) << MAX_ORD)) |-> !rsp_ok);
endmodule

bind buddy_alloc_top buddy_alloc_checker #(.MIN_ORD(MIN_ORD), .MAX_ORD(MAX_ORD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_op    (rsp_op),
  .rsp_ok    (rsp_ok),
  .rsp_addr  (rsp_addr),
  .rsp_order (rsp_order),
  .busy      (busy)
);

// File: tb/buddy_alloc_top_test.sv
module buddy_alloc_top_test;
  localparam int AW = 8;
  localparam int SW = 10;
  localparam int OW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_op;
  logic [SW-1:0] req_size;
  logic [AW-1:0] req_addr;
  logic [OW-1:0] req_order;
  logic          rsp_valid, rsp_ready, rsp_op, rsp_ok, busy;
  logic [AW-1:0] rsp_addr;
  logic [OW-1:0] rsp_order;

  buddy_alloc_top #(.MIN_ORD(4), .MAX_ORD(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_addr(req_addr), .req_order(req_order),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op), .rsp_ok(rsp_ok),
    .rsp_addr(rsp_addr), .rsp_order(rsp_order), .busy(busy)
  );

  typedef struct packed {
    logic          op;
    logic          ok;
    logic [AW-1:0] addr;
    logic [OW-1:0] ord;
    logic [7:0]    cyc;
    logic [7:0]    req;
  } exp_t;

  exp_t expq[$];
  int checks = 0;
  int errors = 0;
  int wait_cnt = 0;
  bit done = 1'b0;

  task automatic check(input bit cond, input int req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard at each response handshake
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid && rsp_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, 10, "response with nothing expected", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(rsp_op == e.op, int'(e.req), "rsp_op", int'(rsp_op), int'(e.op));
          check(rsp_ok == e.ok, int'(e.req), "rsp_ok", int'(rsp_ok), int'(e.ok));
          check(rsp_addr == e.addr, int'(e.req), "rsp_addr", int'(rsp_addr), int'(e.addr));
          check(rsp_order == e.ord, int'(e.req), "rsp_order", int'(rsp_order), int'(e.ord));
          check(wait_cnt == int'(e.cyc), int'(e.req), "busy cycles", wait_cnt, int'(e.cyc));
        end
      end
      if (busy && !rsp_valid) wait_cnt++;
      if (req_valid && req_ready) wait_cnt = 0;
    end
  end

  // driver: pushes the expected item, then issues the request
  task automatic run_op(input logic o, input int size, input int addr, input int ord,
                        input logic eok, input int eaddr, input int eord,
                        input int ecyc, input int req, input bit hold);
    exp_t e;
    e.op = o; e.ok = eok; e.addr = AW'(eaddr); e.ord = OW'(eord);
    e.cyc = 8'(ecyc); e.req = 8'(req);
    expq.push_back(e);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1'b1; req_op = o; req_size = SW'(size);
    req_addr = AW'(addr); req_order = OW'(ord);
    if (hold) rsp_ready = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (hold) begin
      while (!rsp_valid) begin @(posedge clk); #1; end
      repeat (3) @(posedge clk);
      #1;
      // R10: stalled response stays up, block stays busy and closed
      check(rsp_valid && busy && !req_ready, 10, "held response",
            int'({rsp_valid, busy, req_ready}), 6);
      rsp_ready = 1'b1;
    end
    while (expq.size() != 0) begin @(posedge clk); #1; end
  endtask

  task automatic alloc(input int size, input logic eok, input int eaddr, input int eord,
                       input int ecyc, input int req);
    run_op(1'b0, size, 0, 0, eok, eaddr, eord, ecyc, req, 1'b0);
  endtask

  task automatic free_blk(input int addr, input int ord, input logic eok,
                          input int ecyc, input int req);
    run_op(1'b1, 0, addr, ord, eok, addr, ord, ecyc, req, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_size = '0;
    req_addr = '0; req_order = '0; rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: idle state after reset
    check(busy == 1'b0, 1, "busy after reset", int'(busy), 0);
    check(req_ready == 1'b1, 1, "req_ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, 1, "rsp_valid after reset", int'(rsp_valid), 0);

    alloc(256, 1'b1, 0, 8, 1, 1);          // R1: whole pool is one free block
    alloc(1, 1'b0, 0, 0, 1, 6);            // R6: nothing free
    free_blk(0, 8, 1'b1, 2, 7);            // R7: top order, no merge possible
    alloc(300, 1'b0, 0, 0, 1, 5);          // R5: oversize
    alloc(16, 1'b1, 0, 4, 5, 4);           // R4: four splits down to order 4
    alloc(0, 1'b1, 16, 4, 1, 2);           // R2: size 0 served at minimum order
    alloc(17, 1'b1, 32, 5, 1, 2);          // R2: just above 2^4 goes to order 5
    run_op(1'b0, 33, 0, 0, 1'b1, 64, 6, 1, 10, 1'b1); // R10 with stall, R2 order 6
    alloc(129, 1'b0, 0, 0, 1, 6);          // R6: order 8 not free
    alloc(128, 1'b1, 128, 7, 1, 3);        // R3: upper half left by the split
    alloc(16, 1'b0, 0, 0, 1, 6);           // R6: pool full
    free_blk(16, 4, 1'b1, 2, 8);           // R8: buddy at 0 still allocated
    free_blk(16, 4, 1'b0, 1, 9);           // R9: double free refused
    alloc(10, 1'b1, 16, 4, 1, 8);          // R8: freed block handed out again
    free_blk(8, 4, 1'b0, 1, 9);            // R9: misaligned
    free_blk(0, 3, 1'b0, 1, 9);            // R9: order below minimum
    free_blk(0, 5, 1'b0, 1, 9);            // R9: wrong order for block 0
    free_blk(0, 4, 1'b1, 2, 8);            // R8: buddy 16 allocated
    free_blk(16, 4, 1'b1, 3, 7);           // R7: one merge
    free_blk(32, 5, 1'b1, 3, 7);           // R7: one merge
    free_blk(128, 7, 1'b1, 2, 8);          // R8: buddy 0/7 not wholly free
    free_blk(64, 6, 1'b1, 4, 7);           // R7: two merges to the top
    alloc(256, 1'b1, 0, 8, 1, 7);          // R7: pool fully coalesced
    free_blk(0, 8, 1'b1, 2, 7);
    alloc(64, 1'b1, 0, 6, 3, 4);           // R4: two splits
    alloc(64, 1'b1, 64, 6, 1, 3);          // R3: free buddy at order 6
    alloc(64, 1'b1, 128, 6, 2, 3);         // R3: search moves up to order 7
    free_blk(0, 6, 1'b1, 2, 8);
    alloc(50, 1'b1, 0, 6, 1, 3);           // R3: lowest of 0 and 192
    alloc(64, 1'b1, 192, 6, 1, 3);         // R3: remaining block

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule